// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block guards a processor against runaway software. It leaves reset idle and only starts watching once software writes a two-byte key to one service address. The key is the byte 0x1E followed by the byte 0xE1. While it is armed, a 14-bit counter advances on every machine-cycle strobe. Software must repeat the same key before the counter reaches its ceiling, or the block fires a reset pulse.

Nothing software writes can disarm the block. It is cleared only by the external reset or by its own overflow pulse. The pulse is active high and is timed in oscillator clocks. Its length depends on the clock-mode select: a short pulse in the fast (6-clock) mode and a pulse twice as long in the slow (12-clock) mode. After a pulse the block is idle again and waits for a new arming key.

Top module: `wdog_keyed`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `armed` and `rst_pulse` are both 0.
- R2: A write with `wr_en` high, `wr_addr` = 0xA6 and `wr_data` = 0x1E, followed later by a write of 0xE1 to 0xA6, sets `armed` to 1 on the clock edge that samples the 0xE1 write.
- R3: Any write to 0xA6 whose value is not the expected next key byte abandons a partial key. A new 0x1E starts a new partial key. Writes to any other address, and cycles without a write, leave a partial key intact.
- R4: While armed, the counter advances by one on each edge where `mc_tick` is high. With `mc_tick` held high from the arming edge onward, `rst_pulse` rises on the 16384th edge after the arming edge, which is one edge after the count reaches 0x3FFF. With `mc_tick` low, the count does not advance and no pulse is produced.
- R5: A complete key written while armed restarts the count from zero, so the next pulse comes 16384 ticked edges after the edge that sampled the 0xE1.
- R6: Once armed, no write of any value to any address clears `armed`. It stays 1 until an overflow pulse starts or `rst_n` goes low.
- R7: The pulse lasts 98 clock cycles when `mode6` = 1 and 196 clock cycles when `mode6` = 0. The mode is sampled on the edge where the pulse starts.
- R8: The edge that starts the pulse clears `armed`, the count and any partial key. Key writes made while the pulse is high are ignored. After the pulse ends, no further pulse occurs until the block is armed again.
- R9: Driving `rst_n` low while the block is armed clears `armed`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | External reset, active low, asynchronous assert |
| mc_tick | input | 1 | One-cycle strobe, once per machine cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| mode6 | input | 1 | 1 = 6-clock mode (short pulse), 0 = 12-clock mode |
| rst_pulse | output | 1 | Active-high reset pulse produced on overflow |
| armed | output | 1 | High while the watchdog is armed |

## Verification
The checker assumes that `wr_addr` and `wr_data` are defined whenever `wr_en` is high. It also assumes that `rst_n` is not pulsed in the middle of an overflow pulse, so that the pulse-length rule always sees a complete pulse. The stimulus drives every input one time unit after a rising edge. Random writes are drawn from small pools that favour the service address and the two key bytes, so that partial keys, broken keys and restarted keys all occur often. Runs that reach an overflow are directed, with the reset left untouched until the pulse has finished.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic {
        CLK_MODE_12 = 1'b0,
        CLK_MODE_6  = 1'b1
    } clk_mode_e;

    localparam logic [7:0] SVC_ADDR_DEF  = 8'hA6;
    localparam logic [7:0] KEY_FIRST_DEF = 8'h1E;
    localparam logic [7:0] KEY_LAST_DEF  = 8'hE1;
endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR  = 8'hA6,
    parameter logic [DATA_W-1:0] KEY_FIRST = 8'h1E,
    parameter logic [DATA_W-1:0] KEY_LAST  = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              block,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              key_ok
);
    typedef struct packed {
        logic pend;
    } key_st_t;

    key_st_t s_d, s_q;
    logic    hit;

    always_comb begin
        s_d    = s_q;
        key_ok = 1'b0;
        hit    = wr_en && (wr_addr == SVC_ADDR);
        if (block) begin
            s_d.pend = 1'b0;
        end else if (hit) begin
            if (s_q.pend && (wr_data == KEY_LAST)) begin
                key_ok   = 1'b1;
                s_d.pend = 1'b0;
            end else begin
                s_d.pend = (wr_data == KEY_FIRST);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wdog_cycle_ctr.sv
module wdog_cycle_ctr #(
    parameter int CNT_W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic key_ok,
    input  logic tick,
    output logic armed,
    output logic ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        ovf = s_q.armed && (s_q.cnt == CNT_MAX);
        if (kill || ovf) begin
            s_d = '0;
        end else if (key_ok) begin
            s_d.armed = 1'b1;
            s_d.cnt   = '0;
        end else if (s_q.armed && tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    assign armed = s_q.armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen #(
    parameter int LEN_FAST = 98,
    parameter int LEN_SLOW = 196
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fast_mode,
    output logic busy
);
    localparam int LEN_MAX = (LEN_FAST > LEN_SLOW) ? LEN_FAST : LEN_SLOW;
    localparam int LW      = $clog2(LEN_MAX + 1);

    typedef struct packed {
        logic          busy;
        logic [LW-1:0] rem;
    } pls_st_t;

    pls_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.rem == '0) s_d.busy = 1'b0;
            else               s_d.rem  = s_q.rem - 1'b1;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.rem  = fast_mode ? LW'(LEN_FAST - 1) : LW'(LEN_SLOW - 1);
        end
    end

    assign busy = s_q.busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 14,
    parameter int LEN_FAST = 98,
    parameter int LEN_SLOW = 196,
    parameter logic [ADDR_W-1:0] SVC_ADDR  = SVC_ADDR_DEF,
    parameter logic [DATA_W-1:0] KEY_FIRST = KEY_FIRST_DEF,
    parameter logic [DATA_W-1:0] KEY_LAST  = KEY_LAST_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mode6,
    output logic              rst_pulse,
    output logic              armed
);
    logic      key_ok;
    logic      ovf;
    logic      busy;
    clk_mode_e mode;

    assign mode = clk_mode_e'(mode6);

    wdog_key_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR),
        .KEY_FIRST(KEY_FIRST), .KEY_LAST(KEY_LAST)
    ) u_key (
        .clk(clk), .rst_n(rst_n), .block(busy), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .key_ok(key_ok)
    );

    wdog_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .kill(busy), .key_ok(key_ok),
        .tick(mc_tick), .armed(armed), .ovf(ovf)
    );

    wdog_pulse_gen #(.LEN_FAST(LEN_FAST), .LEN_SLOW(LEN_SLOW)) u_pls (
        .clk(clk), .rst_n(rst_n), .start(ovf),
        .fast_mode(mode == CLK_MODE_6), .busy(busy)
    );

    assign rst_pulse = busy;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int LEN_FAST = 98,
    parameter int LEN_SLOW = 196,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 8'hA6,
    parameter logic [DATA_W-1:0] KEY_LAST = 8'hE1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              mode6,
    input logic              rst_pulse,
    input logic              armed
);
    localparam int LEN_MAX = (LEN_FAST > LEN_SLOW) ? LEN_FAST : LEN_SLOW;
    localparam int LW      = $clog2(LEN_MAX + 1);

    logic [LW-1:0] len_q;
    logic          mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            len_q <= rst_pulse ? len_q + 1'b1 : '0;
            if (!rst_pulse) mode_q <= mode6;
        end
    end

    // R2
    arm_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(wr_en && (wr_addr == SVC_ADDR) && (wr_data == KEY_LAST)));

    // R6
    stay_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> (armed || rst_pulse));

    // R8
    pulse_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> !armed);

    // R4
    pulse_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pulse) |-> $past(armed));

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pulse) |-> (len_q == (mode_q ? LW'(LEN_FAST) : LW'(LEN_SLOW))));
endmodule

bind wdog_keyed wdog_keyed_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_FAST(LEN_FAST), .LEN_SLOW(LEN_SLOW),
    .SVC_ADDR(SVC_ADDR), .KEY_LAST(KEY_LAST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode6(mode6), .rst_pulse(rst_pulse), .armed(armed)
);

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       mode6 = 1'b0;
    logic       rst_pulse;
    logic       armed;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    wdog_keyed uut (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .mode6(mode6),
        .rst_pulse(rst_pulse), .armed(armed)
    );

    always #10 clk = ~clk;

    function automatic int exp_len(input logic m6);
        return m6 ? 98 : 196;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic to_pulse(output int n);
        n = 0;
        while (!rst_pulse && n < 20000) begin
            step();
            n++;
        end
    endtask

    task automatic pulse_len(output int n);
        n = 1;
        while (rst_pulse && n < 400) begin
            step();
            if (rst_pulse) n++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int cnt_before;
        bit pend;
        bit exp_arm;
        void'($urandom(32'd1234));

        // R1 reset state
        step();
        chk(armed == 0 && rst_pulse == 0, "R1 during reset", armed, 0);
        rst_n = 1'b1;
        step();
        chk(armed == 0 && rst_pulse == 0, "R1 after release", armed, 0);

        // R3 wrong order and broken key
        wr(8'hA6, 8'hE1); wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
        chk(armed == 0, "R3 broken key", armed, 0);
        // R2 plain arming, first byte alone is not enough
        wr(8'hA6, 8'h1E);
        chk(armed == 0, "R2 half key", armed, 0);
        wr(8'hA6, 8'hE1);
        chk(armed == 1, "R2 full key", armed, 1);

        // R9 external reset disarms
        do_reset();
        chk(armed == 0, "R9 reset clears", armed, 0);

        // R3 other-address write and idle cycles keep the partial key; repeated 0x1E restarts it
        wr(8'hA6, 8'h1E); wr(8'h80, 8'hE1); step(); wr(8'hA6, 8'hE1);
        chk(armed == 1, "R3 other address ignored", armed, 1);
        do_reset();
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        chk(armed == 1, "R3 fresh first byte", armed, 1);

        // R6 nothing disarms; R4 no count without tick
        mc_tick = 1'b0;
        wr(8'hA6, 8'h00); wr(8'hA6, 8'hE1); wr(8'h00, 8'h00); wr(8'hA6, 8'hFF);
        chk(armed == 1, "R6 writes cannot disarm", armed, 1);
        n = 0;
        for (int i = 0; i < 17000; i++) begin
            step();
            if (rst_pulse) n++;
        end
        chk(n == 0 && armed == 1, "R4 no tick no pulse", n, 0);

        // R4 overflow timing, R7 slow pulse length
        do_reset();
        mode6 = 1'b0;
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        mc_tick = 1'b1;
        to_pulse(n);
        chk(n == 16384, "R4 overflow edge", n, 16384);
        chk(armed == 0, "R8 pulse clears armed", armed, 0);
        pulse_len(n);
        chk(n == exp_len(1'b0), "R7 slow pulse", n, exp_len(1'b0));

        // R5 service restarts count, R7 fast pulse, R8 keys ignored during pulse
        mode6 = 1'b1;
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        for (int i = 0; i < 10000; i++) step();
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        to_pulse(n);
        chk(n == 16384, "R5 service restart", n, 16384);
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        n = 3;
        while (rst_pulse && n < 400) begin step(); if (rst_pulse) n++; end
        chk(n == exp_len(1'b1), "R7 fast pulse", n, exp_len(1'b1));
        chk(armed == 0, "R8 key during pulse ignored", armed, 0);
        n = 0;
        for (int i = 0; i < 300; i++) begin
            step();
            if (rst_pulse || armed) n++;
        end
        chk(n == 0, "R8 idle after pulse", n, 0);

        // R2 R3 R6 random write traffic against a bench model
        do_reset();
        pend = 0; exp_arm = 0;
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a, d;
            int r;
            r = $urandom_range(0, 9);
            a = (r < 6) ? 8'hA6 : 8'($urandom);
            r = $urandom_range(0, 9);
            d = (r < 4) ? 8'h1E : (r < 8) ? 8'hE1 : 8'($urandom);
            mc_tick = $urandom_range(0, 1);
            wr_en = $urandom_range(0, 3) != 0;
            wr_addr = a; wr_data = d;
            if (wr_en && a == 8'hA6) begin
                if (pend && d == 8'hE1) begin exp_arm = 1; pend = 0; end
                else pend = (d == 8'h1E);
            end
            step();
            wr_en = 1'b0;
            cnt_before = checks;
            chk(armed == exp_arm && rst_pulse == 0, "R3 random traffic", armed, exp_arm);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule